// File: doc/BRIEF.md
# PCI Outbound Window Control and Address Translation

This block holds the memory-mapped control registers of a PCI host bridge and turns system-side accesses into three outbound memory windows into 32-bit PCI memory addresses. Software programs one base register per window, plus a few plain storage registers, through a simple 32-bit register port. Each window has its own valid/ready request channel. A request carries a window-relative offset. The block forwards the translated PCI address on a matching valid/ready output channel.

A strap input selects how a window base register becomes a PCI address. In nibble mode, the low four bits of the register form the top nibble of the PCI address. In masked mode, the register bits below the window size are cleared and the rest form the base. The window sizes for each mode are parameters.

The request channels apply back-pressure as follows. An in-range request is held until the downstream side is ready: `win_in_ready` follows `win_out_ready`. An out-of-range request produces no output. It is accepted at once, and `win_oor` is raised for as long as it is presented.

Top module: `pciwin_ctl`

## Requirements
- R1: After reset every register reads as zero, and each window translates with a base register of zero.
- R2: A full access (`reg_be` = 4'hF) at a defined word offset stores or returns all 32 bits. The word index is `reg_addr[4:2]`: 0..2 are window bases 0..2, 3 is the identity word, 4 is the flags word, and 5..7 are auxiliary maps 0..2.
- R3: An access at an undefined offset returns zero on `reg_rdata` and changes no register. Undefined means `reg_addr` is 0x20 or higher, or `reg_addr[1:0]` is not zero. In the cycle after such a read or write, `reg_err` is 1 for exactly one cycle.
- R4: A partial access (`reg_be` not equal to 4'hF) behaves like an undefined offset: it returns zero, writes nothing and pulses `reg_err`.
- R5: With `xlat_mode` = 0 (nibble mode), the output address is {base[3:0], 28'h0} + offset. Base bits 31:4 have no effect.
- R6: With `xlat_mode` = 1 (masked mode), the output address is (base AND NOT (size − 1)) + offset.
- R7: The default window sizes are 0x0C000000, 0x10000000 and 0x10000000 in nibble mode, and 0x01000000, 0x04000000 and 0x08000000 in masked mode.
- R8: A request with offset greater than or equal to the window size raises `win_oor`, keeps `win_out_valid` low and is accepted (`win_in_ready` = 1).
- R9: For an in-range request, `win_out_valid` equals `win_in_valid` and `win_in_ready` equals `win_out_ready`.
- R10: A write to a window base register takes effect on that window's translation from the next cycle onward.
- R11: Writing the identity, flags or auxiliary map words has no effect on any window translation.
- R12: `reg_rdata` is zero whenever `reg_re` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlat_mode | input | 1 | Strap: 0 = nibble mode, 1 = masked mode |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_be | input | 4 | Byte enables; only 4'hF is a valid access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| reg_err | output | 1 | One-cycle pulse after a bad access |
| win_in_valid | input | 3 | Request valid, one bit per window |
| win_in_ready | output | 3 | Request accepted, one bit per window |
| win_in_off | input | 96 | Window-relative offsets; window w uses bits [32w+31:32w] |
| win_out_valid | output | 3 | Translated address valid, per window |
| win_out_ready | input | 3 | Downstream ready, per window |
| win_out_addr | output | 96 | Translated PCI addresses; window w uses bits [32w+31:32w] |
| win_oor | output | 3 | Offset out of range, per window |

## Verification
The assertions assume that the mode strap changes only while reset is applied. The stimulus therefore switches `xlat_mode` only inside a reset pulse. They also assume that `reg_we` and `reg_re` are never high in the same cycle, and the stimulus never drives both. Window offsets are driven on either side of each window's size, including size − 1 and exactly size. Downstream readiness is toggled so that both the held case and the accepted case of the handshake occur under the assertions.

// File: rtl/pciwin_pkg.sv
package pciwin_pkg;
  localparam int NWIN   = 3;
  localparam int DW     = 32;
  localparam int ADDR_W = 12;
  localparam int NREG   = 8;
  localparam int IDX_W  = $clog2(NREG);

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
  } reg_sel_t;

  // A legal access is a whole word inside the 8-word bank
  function automatic reg_sel_t reg_decode(input logic [ADDR_W-1:0] a,
                                          input logic [3:0] be);
    reg_sel_t s;
    s.hit = (be == 4'hF) && (a[1:0] == 2'b00) && (a[ADDR_W-1:5] == '0);
    s.idx = a[4:2];
    return s;
  endfunction
endpackage

// File: rtl/pciwin_regs.sv
module pciwin_regs
  import pciwin_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic                 re,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [3:0]           be,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        rdata,
  output logic                 err,
  output logic [NWIN*DW-1:0]   win_base
);
  logic [DW-1:0] store [NREG];
  reg_sel_t      sel;

  assign sel = reg_decode(addr, be);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) store[i] <= '0;
      err <= 1'b0;
    end else begin
      if (we && sel.hit) store[sel.idx] <= wdata;
      err <= (we || re) && !sel.hit;
    end
  end

  always_comb begin
    rdata = '0;
    if (re && sel.hit) rdata = store[sel.idx];
  end

  // Window base registers occupy the first NWIN words
  genvar w;
  generate
    for (w = 0; w < NWIN; w++) begin : g_base
      assign win_base[w*DW +: DW] = store[w];
    end
  endgenerate
endmodule

// File: rtl/pciwin_xlate.sv
module pciwin_xlate
  import pciwin_pkg::*;
#(
  parameter logic [DW-1:0] NIB_SIZE = 32'h1000_0000,
  parameter logic [DW-1:0] MSK_SIZE = 32'h0100_0000
) (
  input  logic          mode,
  input  logic [DW-1:0] base,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] off,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_addr,
  output logic          oor
);
  localparam logic [DW-1:0] NIB_MASK = ~(NIB_SIZE - 32'd1);
  localparam logic [DW-1:0] MSK_MASK = ~(MSK_SIZE - 32'd1);

  logic [DW-1:0] size;
  logic [DW-1:0] origin;
  logic          fits;

  assign size   = mode ? MSK_SIZE : NIB_SIZE;
  assign origin = mode ? (base & MSK_MASK) : {base[3:0], 28'h0};
  assign fits   = off < size;

  assign out_addr  = origin + off;
  assign out_valid = in_valid && fits;
  assign oor       = in_valid && !fits;
  assign in_ready  = fits ? out_ready : 1'b1;

  // Keep the unused mask constant referenced for nibble-mode symmetry
  logic unused_nib;
  assign unused_nib = ^NIB_MASK;
endmodule

// File: rtl/pciwin_ctl.sv
module pciwin_ctl
  import pciwin_pkg::*;
#(
  parameter logic [NWIN*DW-1:0] NIB_SIZES = {32'h1000_0000, 32'h1000_0000, 32'h0C00_0000},
  parameter logic [NWIN*DW-1:0] MSK_SIZES = {32'h0800_0000, 32'h0400_0000, 32'h0100_0000}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 xlat_mode,
  input  logic                 reg_we,
  input  logic                 reg_re,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [3:0]           reg_be,
  input  logic [DW-1:0]        reg_wdata,
  output logic [DW-1:0]        reg_rdata,
  output logic                 reg_err,
  input  logic [NWIN-1:0]      win_in_valid,
  output logic [NWIN-1:0]      win_in_ready,
  input  logic [NWIN*DW-1:0]   win_in_off,
  output logic [NWIN-1:0]      win_out_valid,
  input  logic [NWIN-1:0]      win_out_ready,
  output logic [NWIN*DW-1:0]   win_out_addr,
  output logic [NWIN-1:0]      win_oor
);
  logic [NWIN*DW-1:0] win_base;

  pciwin_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (reg_we),
    .re       (reg_re),
    .addr     (reg_addr),
    .be       (reg_be),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .err      (reg_err),
    .win_base (win_base)
  );

  genvar w;
  generate
    for (w = 0; w < NWIN; w++) begin : g_win
      pciwin_xlate #(
        .NIB_SIZE (NIB_SIZES[w*DW +: DW]),
        .MSK_SIZE (MSK_SIZES[w*DW +: DW])
      ) u_xlate (
        .mode      (xlat_mode),
        .base      (win_base[w*DW +: DW]),
        .in_valid  (win_in_valid[w]),
        .in_ready  (win_in_ready[w]),
        .off       (win_in_off[w*DW +: DW]),
        .out_valid (win_out_valid[w]),
        .out_ready (win_out_ready[w]),
        .out_addr  (win_out_addr[w*DW +: DW]),
        .oor       (win_oor[w])
      );
    end
  endgenerate
endmodule

// File: rtl/pciwin_ctl_chk.sv
module pciwin_ctl_chk
  import pciwin_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               xlat_mode,
  input logic               reg_we,
  input logic               reg_re,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [3:0]         reg_be,
  input logic [DW-1:0]      reg_rdata,
  input logic               reg_err,
  input logic [NWIN-1:0]    win_in_valid,
  input logic [NWIN-1:0]    win_in_ready,
  input logic [NWIN*DW-1:0] win_in_off,
  input logic [NWIN-1:0]    win_out_valid,
  input logic [NWIN-1:0]    win_out_ready,
  input logic [NWIN*DW-1:0] win_out_addr,
  input logic [NWIN-1:0]    win_oor
);
  logic bad_acc;
  assign bad_acc = (reg_addr >= 12'h020) || (reg_addr[1:0] != 2'b00) || (reg_be != 4'hF);

  // Input assumption: the strap only moves during reset
  a_strap_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(xlat_mode));

  // R3, R4: a bad access is flagged in the following cycle
  a_r3_bad_flags_err: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_we || reg_re) && bad_acc) |=> reg_err);

  // R3: no error without a preceding access
  a_r3_err_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we || reg_re) |=> !reg_err);

  // R12: idle read port returns zero
  a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_re |-> (reg_rdata == '0));

  genvar w;
  generate
    for (w = 0; w < NWIN; w++) begin : g_chk
      // R8: out of range and valid output never coincide
      a_r8_oor_no_out: assert property (@(posedge clk) disable iff (!rst_n)
        !(win_oor[w] && win_out_valid[w]));
      // R8: an out-of-range request is accepted
      a_r8_oor_accepted: assert property (@(posedge clk) disable iff (!rst_n)
        win_oor[w] |-> win_in_ready[w]);
      // R9: output valid only for a live request
      a_r9_out_needs_in: assert property (@(posedge clk) disable iff (!rst_n)
        win_out_valid[w] |-> win_in_valid[w]);
      // R9: a held in-range request follows downstream readiness
      a_r9_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
        (win_out_valid[w] && !win_out_ready[w]) |-> !win_in_ready[w]);
      // R5: in nibble mode the low 28 bits pass through unchanged
      a_r5_low_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (!xlat_mode && win_out_valid[w]) |->
          (win_out_addr[w*DW +: 28] == win_in_off[w*DW +: 28]));
    end
  endgenerate
endmodule

bind pciwin_ctl pciwin_ctl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .xlat_mode     (xlat_mode),
  .reg_we        (reg_we),
  .reg_re        (reg_re),
  .reg_addr      (reg_addr),
  .reg_be        (reg_be),
  .reg_rdata     (reg_rdata),
  .reg_err       (reg_err),
  .win_in_valid  (win_in_valid),
  .win_in_ready  (win_in_ready),
  .win_in_off    (win_in_off),
  .win_out_valid (win_out_valid),
  .win_out_ready (win_out_ready),
  .win_out_addr  (win_out_addr),
  .win_oor       (win_oor)
);

// File: tb/pciwin_ctl_bench.sv
module pciwin_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        xlat_mode;
  logic        reg_we, reg_re;
  logic [11:0] reg_addr;
  logic [3:0]  reg_be;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        reg_err;
  logic [2:0]  win_in_valid, win_in_ready, win_out_valid, win_out_ready, win_oor;
  logic [95:0] win_in_off, win_out_addr;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  pciwin_ctl u_pciwin_ctl (
    .clk(clk), .rst_n(rst_n), .xlat_mode(xlat_mode),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_err(reg_err),
    .win_in_valid(win_in_valid), .win_in_ready(win_in_ready), .win_in_off(win_in_off),
    .win_out_valid(win_out_valid), .win_out_ready(win_out_ready),
    .win_out_addr(win_out_addr), .win_oor(win_oor)
  );

  // Reference model state
  logic [31:0] m_reg [8];
  logic        m_err;

  function automatic logic [31:0] win_size(input int w, input logic mode);
    if (mode) return (w == 0) ? 32'h0100_0000 : (w == 1) ? 32'h0400_0000 : 32'h0800_0000;
    return (w == 0) ? 32'h0C00_0000 : 32'h1000_0000;
  endfunction

  function automatic bit acc_ok();
    return reg_be == 4'hF && reg_addr < 12'h020 && reg_addr[1:0] == 2'b00;
  endfunction

  task automatic cmp(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Compare all outputs against the model, then advance one clock
  task automatic step(input string tag);
    logic [31:0] e_rd, base, sz, off, e_addr;
    #2;
    e_rd = (reg_re && acc_ok()) ? m_reg[reg_addr[4:2]] : 32'h0;
    cmp(tag, "rdata", reg_rdata, e_rd);
    cmp(tag, "err", {31'h0, reg_err}, {31'h0, m_err});
    for (int w = 0; w < 3; w++) begin
      base = m_reg[w];
      sz   = win_size(w, xlat_mode);
      off  = win_in_off[w*32 +: 32];
      if (xlat_mode) e_addr = (base & ~(sz - 32'd1)) + off;
      else           e_addr = {base[3:0], 28'h0} + off;
      if (off < sz) begin
        cmp(tag, "out_valid", {31'h0, win_out_valid[w]}, {31'h0, win_in_valid[w]});
        cmp(tag, "in_ready", {31'h0, win_in_ready[w]}, {31'h0, win_out_ready[w]});
        cmp(tag, "oor", {31'h0, win_oor[w]}, 32'h0);
        if (win_in_valid[w]) cmp(tag, "out_addr", win_out_addr[w*32 +: 32], e_addr);
      end else begin
        cmp(tag, "out_valid", {31'h0, win_out_valid[w]}, 32'h0);
        cmp(tag, "oor", {31'h0, win_oor[w]}, {31'h0, win_in_valid[w]});
        if (win_in_valid[w]) cmp(tag, "in_ready", {31'h0, win_in_ready[w]}, 32'h1);
      end
    end
    @(posedge clk);
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) m_reg[i] = 32'h0;
      m_err = 1'b0;
    end else begin
      if (reg_we && acc_ok()) m_reg[reg_addr[4:2]] = reg_wdata;
      m_err = (reg_we || reg_re) && !acc_ok();
    end
    @(negedge clk);
    reg_we = 1'b0; reg_re = 1'b0; reg_be = 4'hF;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be,
                    input string tag);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
    step(tag);
  endtask

  task automatic rd(input logic [11:0] a, input logic [3:0] be, input string tag);
    reg_re = 1'b1; reg_addr = a; reg_be = be;
    step(tag);
  endtask

  task automatic req(input int w, input logic [31:0] off, input logic rdy, input string tag);
    win_in_valid[w] = 1'b1;
    win_in_off[w*32 +: 32] = off;
    win_out_ready[w] = rdy;
  endtask

  task automatic do_reset(input logic mode);
    rst_n = 1'b0;
    xlat_mode = mode;
    step("R1");
    step("R1");
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; xlat_mode = 1'b0;
    reg_we = 1'b0; reg_re = 1'b0; reg_addr = '0; reg_be = 4'hF; reg_wdata = '0;
    win_in_valid = '0; win_in_off = '0; win_out_ready = '0;
    for (int i = 0; i < 8; i++) m_reg[i] = 32'hFFFF_FFFF;
    m_err = 1'b0;
    @(negedge clk);
    do_reset(1'b0);

    // R1: reset values read zero, translation uses zero base
    for (int i = 0; i < 8; i++) rd(12'(i * 4), 4'hF, "R1");
    req(0, 32'h0000_1234, 1'b1, "R1");
    step("R1");

    // R2: store and read back all eight words
    for (int i = 0; i < 8; i++) wr(12'(i * 4), 32'hA5A0_0000 + 32'(i * 32'h1111), 4'hF, "R2");
    for (int i = 0; i < 8; i++) rd(12'(i * 4), 4'hF, "R2");

    // R3: undefined offsets and misaligned addresses
    wr(12'h020, 32'hDEAD_BEEF, 4'hF, "R3");
    step("R3");
    rd(12'h024, 4'hF, "R3");
    wr(12'h002, 32'h1234_5678, 4'hF, "R3");
    rd(12'h000, 4'hF, "R3");
    rd(12'hFFC, 4'hF, "R3");
    step("R3");

    // R4: partial accesses
    wr(12'h004, 32'h0BAD_0BAD, 4'h3, "R4");
    rd(12'h004, 4'hF, "R4");
    rd(12'h008, 4'h1, "R4");
    step("R4");

    // R5, R7, R10: nibble mode with upper base bits set, base used the cycle after the write
    win_in_valid = '0;
    wr(12'h000, 32'hABCD_EF15, 4'hF, "R10");
    req(0, 32'h0BFF_FFFF, 1'b1, "R5");
    req(1, 32'h0FFF_FFFF, 1'b1, "R7");
    req(2, 32'h0000_0010, 1'b1, "R5");
    step("R10");
    wr(12'h008, 32'h0000_0007, 4'hF, "R10");
    step("R10");
    // R8: offsets at exactly the window size and far beyond
    req(0, 32'h0C00_0000, 1'b1, "R8");
    req(1, 32'h1000_0000, 1'b0, "R8");
    req(2, 32'hFFFF_FFFF, 1'b0, "R8");
    step("R8");
    // R9: back-pressure on in-range requests
    req(0, 32'h0000_0100, 1'b0, "R9");
    req(1, 32'h0000_0200, 1'b1, "R9");
    req(2, 32'h0000_0300, 1'b0, "R9");
    step("R9");
    win_in_valid = 3'b010;
    step("R9");
    // R11: auxiliary words leave translation unchanged
    win_in_valid = 3'b111;
    req(0, 32'h0000_0044, 1'b1, "R11");
    wr(12'h00C, 32'hFFFF_FFFF, 4'hF, "R11");
    wr(12'h010, 32'hFFFF_FFFF, 4'hF, "R11");
    wr(12'h014, 32'hFFFF_FFFF, 4'hF, "R11");
    wr(12'h01C, 32'hFFFF_FFFF, 4'hF, "R11");
    step("R11");

    // R6, R7: masked mode after reset with strap changed
    win_in_valid = '0;
    do_reset(1'b1);
    wr(12'h000, 32'hFFFF_FFFF, 4'hF, "R6");
    wr(12'h004, 32'h1234_5678, 4'hF, "R6");
    req(0, 32'h00FF_FFFF, 1'b1, "R6");
    req(1, 32'h03FF_FFFF, 1'b1, "R7");
    req(2, 32'h07FF_FFFF, 1'b1, "R7");
    step("R6");
    wr(12'h008, 32'h8765_4321, 4'hF, "R10");
    step("R10");
    req(0, 32'h0100_0000, 1'b1, "R8");
    req(1, 32'h0400_0000, 1'b0, "R8");
    req(2, 32'h0800_0000, 1'b1, "R8");
    step("R8");
    req(0, 32'h0000_0000, 1'b0, "R9");
    req(1, 32'h0000_0040, 1'b0, "R9");
    req(2, 32'h0000_0080, 1'b1, "R9");
    step("R9");
    // R12: idle read port
    win_in_valid = '0;
    reg_addr = 12'h000;
    step("R12");
    step("R12");

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule